// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Pulse Timer

This block holds two independent clocked monostable channels. Each channel produces a single high pulse on `q` and its inverse on `q_n`. The pulse lasts a programmed number of system clock cycles. A channel can be started from either of two inputs. `trig_rise` fires on its low-to-high step, but only while `trig_fall` is high. `trig_fall` fires on its high-to-low step, but only while `trig_rise` is low. An unused input can therefore be parked at its enabling level.

Each channel has its own active-low clear, its own period and its own mode bit. With `retrig` high, every qualified trigger reloads the full period, so the output stays high until one period after the last trigger. With `retrig` low, the period runs from the first trigger and further triggers are ignored while the output is high. All inputs are taken as already synchronous to `clk`. `rst` is the synchronous active-high reset for the whole block.

Top module: `dual_oneshot`

## Requirements
- R1: A low-to-high step on `trig_rise[i]` while `trig_fall[i]` is high starts a pulse, and `q[i]` is high one clock cycle after the edge is presented.
- R2: A high-to-low step on `trig_fall[i]` while `trig_rise[i]` is low starts a pulse with the same one-cycle latency.
- R3: An edge that is not qualified starts no pulse. This covers a rise on `trig_rise[i]` while `trig_fall[i]` is low, and a fall on `trig_fall[i]` while `trig_rise[i]` is high.
- R4: A pulse started from idle keeps `q[i]` high for exactly `period[i]` cycles. `period[i]` is bits `[16*i+15:16*i]` of `period`.
- R5: With `retrig[i]`=1, a qualified trigger during a pulse reloads the full period, so `q[i]` falls `period[i]` cycles after the last trigger.
- R6: With `retrig[i]`=0, triggers that arrive while `q[i]` is high are ignored, and the pulse ends `period[i]` cycles after the first trigger.
- R7: While `clr_n[i]` is low, `q[i]` goes low one cycle later and stays low, and triggers are ignored.
- R8: A trigger presented in the first cycle in which `clr_n[i]` is high again after being low is ignored.
- R9: A trigger seen while `period[i]` is 0 produces no pulse and does not alter a running pulse.
- R10: `q_n[i]` is the exact inverse of `q[i]` in every cycle.
- R11: `rst` high forces every `q` low and every `q_n` high by the next cycle, and the block leaves reset with no pulse.
- R12: The two channels are independent: a trigger or clear on one channel has no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | NUM_CH | Per-channel active-low clear |
| trig_rise | input | NUM_CH | Rising-edge trigger, qualified by `trig_fall` high |
| trig_fall | input | NUM_CH | Falling-edge trigger, qualified by `trig_rise` low |
| retrig | input | NUM_CH | 1 = retriggerable, 0 = non-retriggerable |
| period | input | NUM_CH*CNT_W | Pulse length in cycles per channel, channel i at bits [CNT_W*i +: CNT_W] |
| q | output | NUM_CH | Pulse output |
| q_n | output | NUM_CH | Inverse of `q` |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. This holds for a trigger raising `q`, for a clear or reset dropping it, and for the end of the period. A pulse started at edge k is therefore high for edges k through k+P-1. The bench drives inputs on the falling edge of the clock. It samples `q` and `q_n` on the next falling edge, before it drives anything new. Pulse widths are measured by counting the falling-edge samples with `q` high. The expected widths are worked out from the trigger timing: P for a single trigger, and gap+P for a retrigger.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
    logic clr_n;
  } edge_hist_t;

  localparam edge_hist_t HIST_RESET = '{rise: 1'b1, fall: 1'b0, clr_n: 1'b0};

  function automatic logic qualified_fire(
    input edge_hist_t prev,
    input logic       rise_now,
    input logic       fall_now,
    input logic       clr_n_now
  );
    logic rise_ok;
    logic fall_ok;
    rise_ok = rise_now && !prev.rise && fall_now;
    fall_ok = !fall_now && prev.fall && !rise_now;
    return clr_n_now && prev.clr_n && (rise_ok || fall_ok);
  endfunction

endpackage

// File: rtl/oneshot_edge_qual.sv
module oneshot_edge_qual
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic trig_rise,
  input  logic trig_fall,
  output logic fire
);

  edge_hist_t hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= HIST_RESET;
    end else begin
      hist.rise  <= trig_rise;
      hist.fall  <= trig_fall;
      hist.clr_n <= clr_n;
    end
  end

  always_comb fire = qualified_fire(hist, trig_rise, trig_fall, clr_n);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             fire,
  input  logic             retrig,
  input  logic [CNT_W-1:0] period,
  output logic             q,
  output logic             q_n
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] remain_nxt;
  logic             q_nxt;
  logic             load;

  always_comb begin
    load       = fire && (period != ZERO) && (retrig || !q);
    q_nxt      = q;
    remain_nxt = remain;
    if (!clr_n) begin
      q_nxt      = 1'b0;
      remain_nxt = ZERO;
    end else if (load) begin
      q_nxt      = 1'b1;
      remain_nxt = period - ONE;
    end else if (q) begin
      if (remain == ZERO) begin
        q_nxt = 1'b0;
      end else begin
        remain_nxt = remain - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 1'b0;
      q_n    <= 1'b1;
      remain <= ZERO;
    end else begin
      q      <= q_nxt;
      q_n    <= ~q_nxt;
      remain <= remain_nxt;
    end
  end

endmodule

// File: rtl/oneshot_channel.sv
module oneshot_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             trig_rise,
  input  logic             trig_fall,
  input  logic             retrig,
  input  logic [CNT_W-1:0] period,
  output logic             q,
  output logic             q_n
);

  logic fire;

  oneshot_edge_qual u_qual (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .trig_rise (trig_rise),
    .trig_fall (trig_fall),
    .fire      (fire)
  );

  oneshot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (clr_n),
    .fire   (fire),
    .retrig (retrig),
    .period (period),
    .q      (q),
    .q_n    (q_n)
  );

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       clr_n,
  input  logic [NUM_CH-1:0]       trig_rise,
  input  logic [NUM_CH-1:0]       trig_fall,
  input  logic [NUM_CH-1:0]       retrig,
  input  logic [NUM_CH*CNT_W-1:0] period,
  output logic [NUM_CH-1:0]       q,
  output logic [NUM_CH-1:0]       q_n
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    oneshot_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .clr_n     (clr_n[i]),
      .trig_rise (trig_rise[i]),
      .trig_fall (trig_fall[i]),
      .retrig    (retrig[i]),
      .period    (period[CNT_W*i +: CNT_W]),
      .q         (q[i]),
      .q_n       (q_n[i])
    );
  end

endmodule

// File: rtl/dual_oneshot_chk.sv
module dual_oneshot_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH-1:0]       clr_n,
  input logic [NUM_CH-1:0]       trig_rise,
  input logic [NUM_CH-1:0]       trig_fall,
  input logic [NUM_CH-1:0]       retrig,
  input logic [NUM_CH*CNT_W-1:0] period,
  input logic [NUM_CH-1:0]       q,
  input logic [NUM_CH-1:0]       q_n
);

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (q == '0) && (q_n == '1)); // R11

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_QN_INVERSE: assert property (@(posedge clk) disable iff (rst)
      q_n[i] == !q[i]); // R10

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
      !clr_n[i] |=> !q[i]); // R7

    AST_ZERO_PERIOD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (period[CNT_W*i +: CNT_W] == '0 && !q[i]) |=> !q[i]); // R9

    AST_RISE_STARTS: assert property (@(posedge clk) disable iff (rst)
      (armed && clr_n[i] && $past(clr_n[i]) && !$past(trig_rise[i]) &&
       trig_rise[i] && trig_fall[i] && period[CNT_W*i +: CNT_W] != '0 &&
       (retrig[i] || !q[i])) |=> q[i]); // R1

    AST_FALL_STARTS: assert property (@(posedge clk) disable iff (rst)
      (armed && clr_n[i] && $past(clr_n[i]) && $past(trig_fall[i]) &&
       !trig_fall[i] && !trig_rise[i] && period[CNT_W*i +: CNT_W] != '0 &&
       (retrig[i] || !q[i])) |=> q[i]); // R2
  end

endmodule

bind dual_oneshot dual_oneshot_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .trig_rise(trig_rise),
  .trig_fall(trig_fall), .retrig(retrig), .period(period), .q(q), .q_n(q_n)
);

// File: tb/dual_oneshot_tb.sv
module dual_oneshot_tb;

  localparam int NUM_CH = 2;
  localparam int CNT_W  = 16;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NUM_CH-1:0]       clr_n = '1;
  logic [NUM_CH-1:0]       trig_rise = '0;
  logic [NUM_CH-1:0]       trig_fall = '1;
  logic [NUM_CH-1:0]       retrig = '1;
  logic [CNT_W-1:0]        per0 = '0;
  logic [CNT_W-1:0]        per1 = '0;
  logic [NUM_CH-1:0]       q;
  logic [NUM_CH-1:0]       q_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  dual_oneshot #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .trig_rise(trig_rise),
    .trig_fall(trig_fall), .retrig(retrig), .period({per1, per0}),
    .q(q), .q_n(q_n)
  );

  // row: retrig, kind (0 rise, 1 fall, 2 both unqualified), period, gap, expected width
  localparam int NROW = 11;
  localparam logic [26:0] VEC [NROW] = '{
    {1'b1, 2'd0, 8'd5, 8'd0, 8'd5},  // R1 R4
    {1'b1, 2'd1, 8'd7, 8'd0, 8'd7},  // R2 R4
    {1'b1, 2'd2, 8'd5, 8'd0, 8'd0},  // R3
    {1'b0, 2'd2, 8'd4, 8'd0, 8'd0},  // R3
    {1'b1, 2'd0, 8'd6, 8'd3, 8'd9},  // R5
    {1'b0, 2'd0, 8'd6, 8'd3, 8'd6},  // R6
    {1'b1, 2'd1, 8'd4, 8'd2, 8'd6},  // R5
    {1'b0, 2'd1, 8'd4, 8'd2, 8'd4},  // R6
    {1'b1, 2'd0, 8'd0, 8'd0, 8'd0},  // R9
    {1'b1, 2'd0, 8'd1, 8'd0, 8'd1},  // R4 boundary
    {1'b1, 2'd0, 8'd6, 8'd3, 8'd9}   // R9 zero on retrigger handled in directed test
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_trig(input int kind);
    case (kind)
      0: trig_rise[0] = 1'b1;
      1: trig_fall[0] = 1'b0;
      default: begin trig_rise[0] = 1'b1; trig_fall[0] = 1'b0; end
    endcase
  endtask

  task automatic idle0();
    trig_rise[0] = 1'b0;
    trig_fall[0] = 1'b1;
  endtask

  initial begin
    int width;
    repeat (3) @(negedge clk);
    check(q == 2'b00 && q_n == 2'b11, "R11 reset", int'(q), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(q == 2'b00, "R11 after reset", int'(q), 0);

    for (int r = 0; r < NROW; r++) begin
      logic [26:0] v;
      v = VEC[r];
      retrig[0] = v[26];
      per0 = CNT_W'(v[23:16]);
      width = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (c >= 1 && q[0]) width++;
        if (q_n[0] != !q[0]) check(1'b0, "R10 inverse", int'(q_n[0]), int'(!q[0]));
        if (q[1]) check(1'b0, "R12 other channel", int'(q[1]), 0);
        if (c == 0) drive_trig(int'(v[25:24]));
        if (c == 1) idle0();
        if (v[15:8] != 0 && c == int'(v[15:8])) drive_trig(int'(v[25:24]));
        if (v[15:8] != 0 && c == int'(v[15:8]) + 1) idle0();
      end
      check(width == int'(v[7:0]), $sformatf("R4/R5/R6 row %0d width", r), width, int'(v[7:0]));
    end

    // R9: zero period retrigger leaves running pulse untouched
    retrig[0] = 1'b1; per0 = 16'd6; width = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (c >= 1 && q[0]) width++;
      if (c == 0) trig_rise[0] = 1'b1;
      if (c == 1) begin trig_rise[0] = 1'b0; per0 = 16'd0; end
      if (c == 3) trig_rise[0] = 1'b1;
      if (c == 4) trig_rise[0] = 1'b0;
    end
    check(width == 6, "R9 zero period retrigger", width, 6);

    // R7 clear aborts pulse and blocks triggers; R8 recovery
    per0 = 16'd20;
    @(negedge clk); trig_rise[0] = 1'b1;
    @(negedge clk); trig_rise[0] = 1'b0;
    check(q[0] == 1'b1, "R1 start before clear", int'(q[0]), 1);
    @(negedge clk); clr_n[0] = 1'b0;
    @(negedge clk);
    check(q[0] == 1'b0 && q_n[0] == 1'b1, "R7 clear drop", int'(q[0]), 0);
    trig_rise[0] = 1'b1;
    @(negedge clk); trig_rise[0] = 1'b0;
    check(q[0] == 1'b0, "R7 trigger during clear", int'(q[0]), 0);
    @(negedge clk);
    clr_n[0] = 1'b1; trig_rise[0] = 1'b1;
    @(negedge clk);
    check(q[0] == 1'b0, "R8 recovery cycle", int'(q[0]), 0);
    @(negedge clk);
    check(q[0] == 1'b0, "R8 held level", int'(q[0]), 0);
    trig_rise[0] = 1'b0;
    @(negedge clk); trig_rise[0] = 1'b1;
    @(negedge clk); trig_rise[0] = 1'b0;
    check(q[0] == 1'b1, "R8 trigger after recovery", int'(q[0]), 1);

    // R12: channel 1 trigger and channel 0 clear are independent
    per1 = 16'd10;
    trig_fall[1] = 1'b0;
    @(negedge clk); trig_fall[1] = 1'b1;
    check(q[1] == 1'b1 && q[0] == 1'b1, "R12 ch1 start", int'(q), 3);
    clr_n[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(q[1] == 1'b1 && q[0] == 1'b0, "R12 ch0 clear only", int'(q), 2);
    clr_n[0] = 1'b1;

    // R11: reset during a pulse
    rst = 1'b1;
    @(negedge clk);
    check(q == 2'b00 && q_n == 2'b11, "R11 reset mid-pulse", int'(q), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(q == 2'b00, "R11 no pulse after reset", int'(q), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule